// File: doc/BRIEF.md
# Carry-Save Array Unsigned Multiplier

This block multiplies two unsigned operands of `W` bits (32 by default) and returns their full `2W`-bit product. An AND array forms one partial-product row per bit of the second operand. Each row is added into running sum and carry vectors by a row of full adders that work in carry-save form, so no carry travels along a row. Each row retires one low product bit. After the last row, one carry-propagate adder merges the remaining sum and carry vectors into the upper half of the product.

A build-time choice swaps the carry-save rows for a chain of conditional-sum adders, one per row, so the two organisations can be compared for area and delay. The final adder is a separate block. It can be built as a ripple chain or as a conditional-sum adder. A second build-time switch registers the product for timing, giving one cycle of latency, or leaves the path purely combinational.

Top module: `csa_mul`

## Requirements
- R1: With the output register on (the default), `product` equals the zero-extended `op_a * op_b` one clock edge after the operands are applied.
- R2: While `rst_n` is low, the registered `product` reads zero.
- R3: If either operand is zero, `product` is zero.
- R4: If one operand is 1, the low `W` bits of `product` equal the other operand and the high `W` bits are zero.
- R5: All-ones times all-ones gives 0xFFFFFFFE_00000001 for `W` = 32. The final carry-propagate adder never produces a carry out of its top bit.
- R6: If one operand is 2^k, `product` equals the other operand shifted left by k.
- R7: The conditional-sum row variant gives the same product, bit for bit, as the carry-save array for every operand pair.
- R8: With the output register off, `product` is valid in the same cycle as the operands, with no clock edge between them.
- R9: Operands with alternating bits (0xAAAAAAAA by 0x55555555 and the reverse) produce the exact product, although carries are generated in every column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| op_a | input | W | Multiplicand, unsigned |
| op_b | input | W | Multiplier, unsigned; bit j selects partial-product row j |
| product | output | 2W | Unsigned product |

## Verification
Zero and unit operands show whether the AND array gates rows correctly and whether the low bits leave the array in the right order. Single-bit powers of two put the whole operand into one row, which exposes row shifting and misrouted carry vectors. All-ones squared and the alternating-bit pairs load every full adder and the final adder to their carry limits, so a dropped or misaligned carry shows up there. Random pairs are compared on the registered carry-save build and on a combinational conditional-sum build at the same time, which tests the two variants against each other and tests the latency of each.

// File: rtl/mulcs_pkg.sv
package mulcs_pkg;
    // Build-time choice of how partial-product rows are accumulated.
    typedef enum logic {
        RED_CARRY_SAVE = 1'b0,
        RED_COND_SUM   = 1'b1
    } red_mode_e;

    // Build-time choice of carry-propagate adder structure.
    typedef enum logic {
        ADD_RIPPLE   = 1'b0,
        ADD_COND_SUM = 1'b1
    } add_kind_e;
endpackage

// File: rtl/csa_row.sv
// One row of full adders in carry-save form: three vectors in, two out.
module csa_row #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    for (genvar i = 0; i < W; i++) begin : g_fa
        assign s[i] = x[i] ^ y[i] ^ z[i];
        assign c[i] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
    end
endmodule

// File: rtl/cpa_adder.sv
// Carry-propagate adder; KIND picks a ripple chain or a conditional-sum tree.
module cpa_adder #(
    parameter int                   W    = 32,
    parameter mulcs_pkg::add_kind_e KIND = mulcs_pkg::ADD_COND_SUM
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    if (KIND == mulcs_pkg::ADD_RIPPLE) begin : g_ripple
        logic [W:0] cy;
        assign cy[0] = cin;
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
        end
        assign cout = cy[W];
    end else begin : g_condsum
        localparam int LVL = (W > 1) ? $clog2(W) : 0;
        localparam int NP  = 1 << LVL;

        logic [NP-1:0] ap, bp, full;
        // per level: sum and block carry for carry-in 0 and carry-in 1
        logic [NP-1:0] s0 [0:LVL];
        logic [NP-1:0] s1 [0:LVL];
        logic [NP-1:0] k0 [0:LVL];
        logic [NP-1:0] k1 [0:LVL];

        always_comb begin
            ap        = '0;
            bp        = '0;
            ap[W-1:0] = a;
            bp[W-1:0] = b;
        end

        assign s0[0] = ap ^ bp;
        assign s1[0] = ~(ap ^ bp);
        assign k0[0] = ap & bp;
        assign k1[0] = ap | bp;

        for (genvar l = 0; l < LVL; l++) begin : g_lvl
            for (genvar i = 0; i < NP; i++) begin : g_bit
                localparam int SZ   = 1 << l;
                localparam int BASE = (i >> (l + 1)) << (l + 1);
                localparam int LO   = BASE + SZ - 1;
                localparam int HI   = BASE + 2 * SZ - 1;
                if (((i / SZ) % 2) == 1) begin : g_up
                    assign s0[l+1][i] = k0[l][LO] ? s1[l][i] : s0[l][i];
                    assign s1[l+1][i] = k1[l][LO] ? s1[l][i] : s0[l][i];
                end else begin : g_dn
                    assign s0[l+1][i] = s0[l][i];
                    assign s1[l+1][i] = s1[l][i];
                end
                assign k0[l+1][i] = k0[l][LO] ? k1[l][HI] : k0[l][HI];
                assign k1[l+1][i] = k1[l][LO] ? k1[l][HI] : k0[l][HI];
            end
        end

        assign full = cin ? s1[LVL] : s0[LVL];
        assign sum  = full[W-1:0];
        if (NP > W) begin : g_pad
            assign cout = full[W];
        end else begin : g_exact
            assign cout = cin ? k1[LVL][0] : k0[LVL][0];
        end

        logic unused_bits;
        assign unused_bits = ^{k0[LVL], k1[LVL], full};
    end
endmodule

// File: rtl/csa_mul.sv
// Unsigned array multiplier, W x W -> 2W, with carry-save row reduction.
module csa_mul #(
    parameter int                   W        = 32,
    parameter bit                   REG_OUT  = 1'b1,
    parameter mulcs_pkg::red_mode_e RED_MODE = mulcs_pkg::RED_CARRY_SAVE,
    parameter mulcs_pkg::add_kind_e FIN_ADD  = mulcs_pkg::ADD_COND_SUM
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic [2*W-1:0] product
);
    localparam int PW = 2 * W;

    logic [W-1:0]  lo_bits;
    logic [W-1:0]  hi_bits;
    logic          final_cout;
    logic [PW-1:0] prod_comb;

    if (RED_MODE == mulcs_pkg::RED_CARRY_SAVE) begin : g_csa
        logic [W-1:0] rs [0:W];
        logic [W-1:0] rc [0:W];
        assign rs[0] = '0;
        assign rc[0] = '0;
        for (genvar j = 0; j < W; j++) begin : g_row
            csa_row #(.W(W)) u_row (
                .x ({1'b0, rs[j][W-1:1]}),
                .y (rc[j]),
                .z (op_a & {W{op_b[j]}}),
                .s (rs[j+1]),
                .c (rc[j+1])
            );
            assign lo_bits[j] = rs[j+1][0];
        end
        cpa_adder #(.W(W), .KIND(FIN_ADD)) u_final (
            .a    ({1'b0, rs[W][W-1:1]}),
            .b    (rc[W]),
            .cin  (1'b0),
            .sum  (hi_bits),
            .cout (final_cout)
        );
        logic unused_bits;
        assign unused_bits = rs[0][0];
    end else begin : g_cond
        logic [W:0] acc [0:W];
        assign acc[0] = '0;
        for (genvar j = 0; j < W; j++) begin : g_row
            cpa_adder #(.W(W), .KIND(mulcs_pkg::ADD_COND_SUM)) u_row (
                .a    (acc[j][W:1]),
                .b    (op_a & {W{op_b[j]}}),
                .cin  (1'b0),
                .sum  (acc[j+1][W-1:0]),
                .cout (acc[j+1][W])
            );
            assign lo_bits[j] = acc[j+1][0];
        end
        assign hi_bits    = acc[W][W:1];
        assign final_cout = 1'b0;
        logic unused_bits;
        assign unused_bits = acc[0][0];
    end

    assign prod_comb = {hi_bits, lo_bits};

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                product <= '0;
            end else begin
                product <= prod_comb;
            end
        end
    end else begin : g_comb
        assign product = prod_comb;
        logic unused_ctl;
        assign unused_ctl = clk ^ rst_n;
    end
endmodule

// File: rtl/csa_mul_chk.sv
// Property checker for csa_mul, attached to every instance by bind.
module csa_mul_chk #(
    parameter int                   W        = 32,
    parameter bit                   REG_OUT  = 1'b1,
    parameter mulcs_pkg::red_mode_e RED_MODE = mulcs_pkg::RED_CARRY_SAVE
) (
    input logic           clk,
    input logic           rst_n,
    input logic [W-1:0]   op_a,
    input logic [W-1:0]   op_b,
    input logic [2*W-1:0] product,
    input logic           final_cout
);
    logic [2*W-1:0] ref_prod;
    assign ref_prod = {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};

    logic seen_rst = 1'b0;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
    end

    if (REG_OUT) begin : g_reg
        // R1
        product_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> product == $past(ref_prod));

        // R2
        reset_clear_chk: assert property (@(posedge clk)
            (!rst_n && seen_rst) |-> product == '0);

        // R3
        zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(op_a) == '0 || $past(op_b) == '0)) |-> product == '0);

        // R4
        unit_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_b) == W'(1)) |->
                (product[W-1:0] == $past(op_a) && product[2*W-1:W] == '0));
    end else begin : g_comb
        // R8
        comb_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            product == ref_prod);

        // R3
        zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_a == '0 || op_b == '0) |-> product == '0);
    end

    if (RED_MODE == mulcs_pkg::RED_CARRY_SAVE) begin : g_top_carry
        // R5
        no_top_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !final_cout);
    end else begin : g_no_top_carry
        logic unused_cout;
        assign unused_cout = final_cout;
    end
endmodule

bind csa_mul csa_mul_chk #(
    .W        (W),
    .REG_OUT  (REG_OUT),
    .RED_MODE (RED_MODE)
) u_csa_mul_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_a       (op_a),
    .op_b       (op_b),
    .product    (product),
    .final_cout (final_cout)
);

// File: tb/test_csa_mul.sv
module test_csa_mul;
    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [W-1:0]   op_a;
    logic [W-1:0]   op_b;
    logic [2*W-1:0] prod_r;
    logic [2*W-1:0] prod_c;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    // registered carry-save build (defaults)
    csa_mul #(.W(W)) i_csa_mul (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .product(prod_r)
    );

    // combinational conditional-sum build
    csa_mul #(
        .W(W), .REG_OUT(1'b0), .RED_MODE(mulcs_pkg::RED_COND_SUM)
    ) i_csa_mul_cs (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .product(prod_c)
    );

    task automatic check(input string tag, input logic [2*W-1:0] got,
                         input logic [2*W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive at a falling edge; combinational build checked at once,
    // registered build checked after the next rising edge.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input string tag);
        logic [2*W-1:0] exp;
        exp = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        @(negedge clk);
        op_a = a;
        op_b = b;
        #1;
        check({tag, " [R7 R8 cond-sum comb]"}, prod_c, exp);
        @(negedge clk);
        check({tag, " [R1 registered]"}, prod_r, exp);
    endtask

    task automatic t_reset();
        op_a  = 32'd5;
        op_b  = 32'd7;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 reset holds product at zero", prod_r, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_zero();
        apply(32'h0, 32'h0, "R3 zero by zero");
        apply(32'hDEAD_BEEF, 32'h0, "R3 operand b zero");
        apply(32'h0, 32'hFFFF_FFFF, "R3 operand a zero");
    endtask

    task automatic t_unit();
        apply(32'h1234_5678, 32'h1, "R4 times one");
        apply(32'h1, 32'hFFFF_FFFF, "R4 one times max");
    endtask

    task automatic t_allones();
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 all-ones squared");
        @(negedge clk);
        check("R5 literal all-ones product", prod_r, 64'hFFFF_FFFE_0000_0001);
    endtask

    task automatic t_pow2();
        for (int k = 0; k < W; k += 7) begin
            apply(32'hC3A5_0F1E, 32'h1 << k, "R6 power of two in b");
        end
        apply(32'h8000_0000, 32'h8000_0000, "R6 top bits only");
    endtask

    task automatic t_alternate();
        apply(32'hAAAA_AAAA, 32'h5555_5555, "R9 alternating a5");
        apply(32'h5555_5555, 32'hAAAA_AAAA, "R9 alternating 5a");
    endtask

    task automatic t_random();
        for (int n = 0; n < 40; n++) begin
            apply($urandom(), $urandom(), "R1 R7 random pair");
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        op_a  = '0;
        op_b  = '0;
        rst_n = 1'b0;
        t_reset();
        t_zero();
        t_unit();
        t_allones();
        t_pow2();
        t_alternate();
        t_random();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule